// File: doc/BRIEF.md
# System Bus Address Decoder with Boot Overlay

This block sits between a 16-bit CPU bus and the memories of a small console-style memory map. Every cycle it decodes the CPU address into a region select and a local offset. The regions are fixed ROM, switchable ROM, video RAM, cartridge RAM and work RAM. On reads it returns the data of the selected memory on one byte-wide bus. The memories and the bank controller sit outside the block. Each one receives its select, the shared offset and a write strobe, and returns its read data on its own input.

After reset a 256-byte boot program covers the bottom of the fixed ROM. The overlay switches itself off for good the first time the CPU reads fixed ROM between 0x0100 and 0x0FFF. Writes anywhere in the ROM window go to the bank controller's register interface and never reach ROM storage. Cartridge RAM accesses go to the bank controller when the cartridge has one. Otherwise reads return zero, and writes go straight to the cartridge RAM if one is fitted. Work RAM also answers in the 0xE000–0xFFFF mirror.

A cycle with both `cpu_rd` and `cpu_wr` high is handled as a write.

Top module: `sysbus_decoder`

## Requirements
- R1: After reset `boot_active` is 1. While it is 1, a read below 0x0100 asserts `boot_cs` and not `rom_cs`, and it returns `boot_rdata`. The boot memory is indexed by `local_ofs[7:0]` = address[7:0].
- R2: While `boot_active` is 1, a read in 0x0100–0x0FFF asserts `rom_cs` and returns `rom_rdata`. `boot_active` is 0 from the next cycle onward. It stays 0 until the next reset, so later reads below 0x0100 return ROM data.
- R3: While `boot_active` is 1, the following leave it at 1: reads at 0x1000 and above, reads below 0x0100, all writes, and idle cycles.
- R4: A read in 0x0000–0x7FFF (with no boot hit) asserts `rom_cs`. `local_ofs` is address[13:0]. `rom_upper` is 0 for 0x0000–0x3FFF and 1 for 0x4000–0x7FFF. The read returns `rom_rdata`.
- R5: A write in 0x0000–0x7FFF asserts `map_reg_we` for that cycle. It asserts no select and not `mem_we`.
- R6: An access in 0x8000–0x9FFF asserts `vram_cs` with `local_ofs` = {0, address[12:0]}. A read returns `vram_rdata`. A write asserts `mem_we`.
- R7: With `cart_has_mapper` = 1, an access in 0xA000–0xBFFF asserts `map_ram_cs`. A read returns `map_ram_rdata`. A write asserts `mem_we`.
- R8: With `cart_has_mapper` = 0, a read in 0xA000–0xBFFF returns 0x00 and asserts no select. A write there asserts `eram_cs` and `mem_we` only when `eram_fitted` is 1. Otherwise it asserts no strobe at all.
- R9: An access in 0xC000–0xFFFF asserts `wram_cs` with `local_ofs` = {0, address[12:0]}. An address and its mirror 0x2000 higher select the same offset.
- R10: At most one of the selects and `map_reg_we` is high in any cycle. With `cpu_rd` and `cpu_wr` both low, no select or strobe is high and `cpu_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read request this cycle |
| cpu_wr | input | 1 | Write request this cycle |
| cart_has_mapper | input | 1 | Cartridge carries a bank controller |
| eram_fitted | input | 1 | Cartridge RAM present (used when there is no mapper) |
| boot_rdata | input | 8 | Boot memory read data |
| rom_rdata | input | 8 | ROM read data |
| vram_rdata | input | 8 | Video RAM read data |
| wram_rdata | input | 8 | Work RAM read data |
| map_ram_rdata | input | 8 | Cartridge RAM data via bank controller |
| cpu_rdata | output | 8 | Read data returned to CPU |
| boot_active | output | 1 | Boot overlay flag |
| boot_cs | output | 1 | Boot memory read select |
| rom_cs | output | 1 | ROM read select |
| rom_upper | output | 1 | Switchable ROM window selected |
| vram_cs | output | 1 | Video RAM select |
| wram_cs | output | 1 | Work RAM select |
| map_ram_cs | output | 1 | Cartridge RAM select via bank controller |
| eram_cs | output | 1 | Direct cartridge RAM write select |
| map_reg_we | output | 1 | Bank controller register write |
| mem_we | output | 1 | Write strobe for the selected RAM |
| local_ofs | output | 14 | Offset inside the selected region |

## Verification
The only state is the boot flag, and a wrong value shows at the ports within one access. A stuck flag returns boot bytes instead of ROM data on a read below 0x0100. A flag cleared too early returns ROM data where boot bytes are expected. The bench therefore reads the low page straight after each event that could change the flag. Decode faults show in the same cycle: as a wrong select, a wrong offset, a wrong data byte, or a stray write strobe in the ROM window.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;

    typedef enum logic [2:0] {
        RG_ROM_FIX,
        RG_ROM_BANK,
        RG_VRAM,
        RG_XRAM,
        RG_WRAM
    } region_e;

    typedef struct packed {
        logic active;
    } boot_state_t;

endpackage

// File: rtl/sysbus_region_decode.sv
module sysbus_region_decode
    import sysbus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROM_OFS_W = 14,
    parameter int RAM_OFS_W = 13
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output region_e              region_o,
    output logic [ROM_OFS_W-1:0] ofs_o
);
    localparam int TOP_W = ADDR_W - RAM_OFS_W;

    logic [TOP_W-1:0] top;

    always_comb begin
        top = addr_i[ADDR_W-1 -: TOP_W];
        unique case (top)
            3'd0, 3'd1: region_o = RG_ROM_FIX;
            3'd2, 3'd3: region_o = RG_ROM_BANK;
            3'd4:       region_o = RG_VRAM;
            3'd5:       region_o = RG_XRAM;
            default:    region_o = RG_WRAM;
        endcase
        if (region_o == RG_ROM_FIX || region_o == RG_ROM_BANK) begin
            ofs_o = addr_i[ROM_OFS_W-1:0];
        end else begin
            ofs_o = {{(ROM_OFS_W-RAM_OFS_W){1'b0}}, addr_i[RAM_OFS_W-1:0]};
        end
    end

endmodule

// File: rtl/sysbus_boot_overlay.sv
module sysbus_boot_overlay
    import sysbus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BOOT_BYTES = 256,
    parameter int CLEAR_END  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              active_o,
    output logic              hit_o
);
    localparam logic [ADDR_W-1:0] BOOT_TOP  = ADDR_W'(BOOT_BYTES);
    localparam logic [ADDR_W-1:0] CLEAR_TOP = ADDR_W'(CLEAR_END);

    boot_state_t state_d, state_q;
    logic        in_boot, in_clear;

    always_comb begin
        in_boot  = addr_i < BOOT_TOP;
        in_clear = (addr_i >= BOOT_TOP) && (addr_i < CLEAR_TOP);
        state_d  = state_q;
        if (state_q.active && rd_i && in_clear) begin
            state_d.active = 1'b0;
        end
        hit_o    = state_q.active && rd_i && in_boot;
        active_o = state_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{active: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    // R2: a read in the clear window ends the overlay
    a_r2_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && rd_i && addr_i >= BOOT_TOP && addr_i < CLEAR_TOP) |=> !active_o);
    // R2: once cleared, never set again before reset
    a_r2_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |=> !active_o);
    // R3: any other cycle keeps the overlay
    a_r3_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !(rd_i && addr_i >= BOOT_TOP && addr_i < CLEAR_TOP)) |=> active_o);

endmodule

// File: rtl/sysbus_rdata_mux.sv
module sysbus_rdata_mux
    import sysbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  region_e           region_i,
    input  logic              rd_i,
    input  logic              boot_hit_i,
    input  logic              mapper_i,
    input  logic [DATA_W-1:0] boot_i,
    input  logic [DATA_W-1:0] rom_i,
    input  logic [DATA_W-1:0] vram_i,
    input  logic [DATA_W-1:0] wram_i,
    input  logic [DATA_W-1:0] map_ram_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (region_i)
                RG_ROM_FIX:  rdata_o = boot_hit_i ? boot_i : rom_i;
                RG_ROM_BANK: rdata_o = rom_i;
                RG_VRAM:     rdata_o = vram_i;
                RG_XRAM:     rdata_o = mapper_i ? map_ram_i : '0;
                RG_WRAM:     rdata_o = wram_i;
                default:     rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/sysbus_decoder.sv
module sysbus_decoder
    import sysbus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int ROM_OFS_W  = 14,
    parameter int RAM_OFS_W  = 13,
    parameter int BOOT_BYTES = 256,
    parameter int CLEAR_END  = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    input  logic                 cart_has_mapper,
    input  logic                 eram_fitted,
    input  logic [DATA_W-1:0]    boot_rdata,
    input  logic [DATA_W-1:0]    rom_rdata,
    input  logic [DATA_W-1:0]    vram_rdata,
    input  logic [DATA_W-1:0]    wram_rdata,
    input  logic [DATA_W-1:0]    map_ram_rdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 boot_active,
    output logic                 boot_cs,
    output logic                 rom_cs,
    output logic                 rom_upper,
    output logic                 vram_cs,
    output logic                 wram_cs,
    output logic                 map_ram_cs,
    output logic                 eram_cs,
    output logic                 map_reg_we,
    output logic                 mem_we,
    output logic [ROM_OFS_W-1:0] local_ofs
);
    region_e region;
    logic    rd_only, access, boot_hit, rom_win;

    assign rd_only = cpu_rd && !cpu_wr;
    assign access  = cpu_rd || cpu_wr;

    sysbus_region_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_OFS_W(ROM_OFS_W),
        .RAM_OFS_W(RAM_OFS_W)
    ) i_decode (
        .addr_i  (cpu_addr),
        .region_o(region),
        .ofs_o   (local_ofs)
    );

    sysbus_boot_overlay #(
        .ADDR_W    (ADDR_W),
        .BOOT_BYTES(BOOT_BYTES),
        .CLEAR_END (CLEAR_END)
    ) i_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (rd_only),
        .addr_i  (cpu_addr),
        .active_o(boot_active),
        .hit_o   (boot_hit)
    );

    sysbus_rdata_mux #(
        .DATA_W(DATA_W)
    ) i_mux (
        .region_i  (region),
        .rd_i      (rd_only),
        .boot_hit_i(boot_hit),
        .mapper_i  (cart_has_mapper),
        .boot_i    (boot_rdata),
        .rom_i     (rom_rdata),
        .vram_i    (vram_rdata),
        .wram_i    (wram_rdata),
        .map_ram_i (map_ram_rdata),
        .rdata_o   (cpu_rdata)
    );

    always_comb begin
        rom_win    = (region == RG_ROM_FIX) || (region == RG_ROM_BANK);
        boot_cs    = boot_hit;
        rom_cs     = rd_only && rom_win && !boot_hit;
        rom_upper  = rom_cs && (region == RG_ROM_BANK);
        map_reg_we = cpu_wr && rom_win;
        vram_cs    = access && (region == RG_VRAM);
        wram_cs    = access && (region == RG_WRAM);
        map_ram_cs = access && (region == RG_XRAM) && cart_has_mapper;
        eram_cs    = cpu_wr && (region == RG_XRAM) && !cart_has_mapper && eram_fitted;
        mem_we     = cpu_wr && (vram_cs || wram_cs || map_ram_cs || eram_cs);
    end

    // R10: selects and register write are mutually exclusive
    a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({boot_cs, rom_cs, vram_cs, wram_cs, map_ram_cs, eram_cs, map_reg_we}));
    // R10: idle bus drives nothing
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (cpu_rdata == '0 && !mem_we && !map_reg_we));
    // R5: ROM storage never sees a write
    a_r5_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> (!rom_cs && !boot_cs));
    // R8: no mapper, cartridge RAM reads as zero
    a_r8_xram_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && cpu_addr[15:13] == 3'd5 && !cart_has_mapper) |-> cpu_rdata == '0);
    // R9: both work RAM ranges index with the low address bits
    a_r9_mirror_ofs: assert property (@(posedge clk) disable iff (!rst_n)
        wram_cs |-> local_ofs[RAM_OFS_W-1:0] == cpu_addr[RAM_OFS_W-1:0]);
    // R1: boot flag comes out of reset set
    a_r1_boot_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> boot_active);

endmodule

// File: tb/test_sysbus_decoder.sv
module test_sysbus_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic        cart_has_mapper = 1'b1, eram_fitted = 1'b1;
    logic [7:0]  boot_rdata, rom_rdata, vram_rdata, wram_rdata, map_ram_rdata, cpu_rdata;
    logic        boot_active, boot_cs, rom_cs, rom_upper, vram_cs, wram_cs;
    logic        map_ram_cs, eram_cs, map_reg_we, mem_we;
    logic [13:0] local_ofs;

    int  n_checks = 0;
    int  n_errors = 0;
    logic exp_boot = 1'b1;
    logic done = 1'b0;

    always #5 clk = ~clk;

    // memory models answer from the offset the block drives
    assign boot_rdata    = local_ofs[7:0] ^ 8'hC3;
    assign rom_rdata     = local_ofs[7:0] ^ {2'b00, local_ofs[13:8]} ^ (rom_upper ? 8'h5A : 8'h00);
    assign vram_rdata    = local_ofs[7:0] + 8'h11;
    assign wram_rdata    = local_ofs[7:0] ^ {3'b000, local_ofs[12:8]} ^ 8'h96;
    assign map_ram_rdata = local_ofs[7:0] ^ 8'h3C;

    sysbus_decoder i_sysbus_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cart_has_mapper(cart_has_mapper), .eram_fitted(eram_fitted),
        .boot_rdata(boot_rdata), .rom_rdata(rom_rdata), .vram_rdata(vram_rdata),
        .wram_rdata(wram_rdata), .map_ram_rdata(map_ram_rdata), .cpu_rdata(cpu_rdata),
        .boot_active(boot_active), .boot_cs(boot_cs), .rom_cs(rom_cs), .rom_upper(rom_upper),
        .vram_cs(vram_cs), .wram_cs(wram_cs), .map_ram_cs(map_ram_cs), .eram_cs(eram_cs),
        .map_reg_we(map_reg_we), .mem_we(mem_we), .local_ofs(local_ofs)
    );

    function automatic logic [7:0] exp_data(input logic [15:0] a, input logic rd, input logic wr,
                                            input logic boot, input logic mapper);
        logic [13:0] ro;
        logic [12:0] mo;
        ro = a[13:0];
        mo = a[12:0];
        if (!rd || wr) return 8'h00;
        if (a[15] == 1'b0) begin
            if (boot && a < 16'h0100) return a[7:0] ^ 8'hC3;
            return ro[7:0] ^ {2'b00, ro[13:8]} ^ (a[14] ? 8'h5A : 8'h00);
        end
        if (a[15:13] == 3'd4) return mo[7:0] + 8'h11;
        if (a[15:13] == 3'd5) return mapper ? (mo[7:0] ^ 8'h3C) : 8'h00;
        return mo[7:0] ^ {3'b000, mo[12:8]} ^ 8'h96;
    endfunction

    // {boot_cs, rom_cs, rom_upper, vram_cs, wram_cs, map_ram_cs, eram_cs, map_reg_we, mem_we}
    function automatic logic [8:0] exp_strobes(input logic [15:0] a, input logic rd, input logic wr,
                                               input logic boot, input logic mapper, input logic fit);
        logic rdo, acc, bt, rm, vr, wm, mr, er, rw;
        rdo = rd && !wr;
        acc = rd || wr;
        bt  = rdo && boot && !a[15] && a < 16'h0100;
        rm  = rdo && !a[15] && !bt;
        vr  = acc && a[15:13] == 3'd4;
        wm  = acc && a[15:14] == 2'b11;
        mr  = acc && a[15:13] == 3'd5 && mapper;
        er  = wr && a[15:13] == 3'd5 && !mapper && fit;
        rw  = wr && !a[15];
        return {bt, rm, rm && a[14], vr, wm, mr, er, rw, wr && (vr || wm || mr || er)};
    endfunction

    function automatic logic [13:0] exp_ofs(input logic [15:0] a);
        if (!a[15]) return a[13:0];
        return {1'b0, a[12:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input string req, input logic [15:0] a, input logic rd, input logic wr);
        @(negedge clk);
        cpu_addr = a;
        cpu_rd   = rd;
        cpu_wr   = wr;
        #2;
        check({req, " rdata"}, 32'(cpu_rdata), 32'(exp_data(a, rd, wr, exp_boot, cart_has_mapper)));
        check({req, " strobes"},
              32'({boot_cs, rom_cs, rom_upper, vram_cs, wram_cs, map_ram_cs, eram_cs, map_reg_we, mem_we}),
              32'(exp_strobes(a, rd, wr, exp_boot, cart_has_mapper, eram_fitted)));
        check({req, " offset"}, 32'(local_ofs), 32'(exp_ofs(a)));
        @(posedge clk);
        if (rd && !wr && exp_boot && a >= 16'h0100 && a < 16'h1000) exp_boot = 1'b0;
    endtask

    task automatic flag_check(input string req);
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        #1;
        check(req, 32'(boot_active), 32'(exp_boot));
        check({req, " idle R10"}, 32'(cpu_rdata), 32'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_boot = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        flag_check("R1 flag after reset");
        access("R1 boot read", 16'h0042, 1'b1, 1'b0);
        access("R1 boot read top", 16'h00FF, 1'b1, 1'b0);
        access("R3 high fixed rom read", 16'h2000, 1'b1, 1'b0);
        access("R3 write at 0x0150", 16'h0150, 1'b0, 1'b1);
        flag_check("R3 flag kept");
        access("R4 banked rom", 16'h7ABC, 1'b1, 1'b0);
        access("R2 clearing read", 16'h0100, 1'b1, 1'b0);
        flag_check("R2 flag cleared");
        access("R2 low page now rom", 16'h0042, 1'b1, 1'b0);
        access("R5 rom write", 16'h2100, 1'b0, 1'b1);
        access("R6 vram read", 16'h9FFF, 1'b1, 1'b0);
        access("R6 vram write", 16'h8001, 1'b0, 1'b1);
        access("R9 wram", 16'hC123, 1'b1, 1'b0);
        access("R9 mirror", 16'hE123, 1'b1, 1'b0);
        access("R9 top", 16'hFFFF, 1'b1, 1'b0);
        access("R7 mapper ram read", 16'hA055, 1'b1, 1'b0);
        access("R7 mapper ram write", 16'hBFFF, 1'b0, 1'b1);
        cart_has_mapper = 1'b0;
        access("R8 no mapper read", 16'hA055, 1'b1, 1'b0);
        access("R8 direct write", 16'hA010, 1'b0, 1'b1);
        eram_fitted = 1'b0;
        access("R8 write no ram", 16'hB010, 1'b0, 1'b1);
        access("R10 idle", 16'hC000, 1'b0, 1'b0);

        do_reset();
        cart_has_mapper = 1'b1;
        flag_check("R1 flag after second reset");
        access("R2 clear at 0x0FFF", 16'h0FFF, 1'b1, 1'b0);
        flag_check("R2 cleared by 0x0FFF");
        access("R2 sticky low read", 16'h0000, 1'b1, 1'b0);

        do_reset();
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            logic [1:0]  op;
            a  = 16'($urandom);
            op = 2'($urandom);
            if (($urandom % 4) == 0) a = {8'h00, a[7:0]} | (($urandom % 2) == 0 ? 16'h0000 : 16'h0F00);
            cart_has_mapper = 1'($urandom);
            eram_fitted     = 1'($urandom);
            access("R4 R6 R7 R8 R9 R10 random", a, op[0], op[1]);
            if ((i % 50) == 0) flag_check("R2 R3 random flag");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule